// File: doc/BRIEF.md
# Die-aware serial flash read sequencer

This block is the master side of an SPI link to a serial NOR flash whose array is split into several equally sized dies. Each die wraps its internal address counter at its own end rather than running into the next one. A caller hands over one request with an operation, a start byte address and a byte length. The sequencer then drives chip select, SCLK and MOSI, samples MISO, and returns the read bytes on a valid/ready byte stream.

When a read runs off the end of a die, the sequencer closes the current transaction. It then opens a new read at the base of the next die, so the caller receives one unbroken stream. The same per-die splitting turns a whole-device erase into one die-erase command per die, issued in ascending order. A fixed three-byte identification read is also provided.

Each request ends with a one-cycle completion pulse. Parameters set the die size, the number of dies, the SCLK divider and the minimum chip-select high time.

Top module: `flash_seq`

## Requirements
- R1: Out of reset, chip select is high, SCLK is low, the request port is ready, and no byte or completion is signalled.
- R2: The bus runs in SPI mode 0. SCLK idles low whenever chip select is high, and MOSI does not change on a rising SCLK edge. Every byte is shifted most significant bit first in both directions.
- R3: A read transaction (req_op_i = 0) sends opcode 0x03 and then four address bytes, most significant first. The address is zero-extended to 32 bits.
- R4: A read of N bytes delivers exactly N bytes, in the order of ascending address from the start address.
- R5: When the running address of a read reaches a die base (low DIE_BITS bits all zero), chip select is raised and a fresh read is issued at that base address. Past the last die, this base is address 0.
- R6: An identification request (req_op_i = 1) sends opcode 0x9F and clocks in exactly three bytes within one transaction, whatever req_len_i holds.
- R7: An erase request (req_op_i = 2) issues NUM_DIES transactions. Each one sends opcode 0xC4 followed by the four-byte base address of one die, in ascending die order. No bytes appear on the output stream.
- R8: A read of length zero gives a completion pulse in the cycle after acceptance, with chip select never going low.
- R9: While rd_valid_o is high and rd_ready_i is low, rd_valid_o and rd_data_o hold their values and SCLK does not toggle.
- R10: Chip select stays high for at least CS_GAP_SCLK full SCLK periods before every falling edge.
- R11: done_o is a single-cycle pulse at the end of each request, and req_ready_o is low while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle, request taken when valid |
| req_op_i | input | 2 | 0 read, 1 identification, 2 whole-device erase |
| req_addr_i | input | ADDR_W | Start byte address for a read |
| req_len_i | input | LEN_W | Read length in bytes |
| rd_data_o | output | 8 | Returned byte |
| rd_valid_o | output | 1 | Returned byte valid |
| rd_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | Request complete pulse |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Master data out |
| spi_miso_i | input | 1 | Slave data in |

## Verification
The bench builds the block with 64-byte dies (DIE_BITS = 6) and four dies, which gives an 8-bit address space. This lets reads of a few dozen bytes cross one or two die boundaries and also run off the top of the device back to address 0. CLK_DIV = 1 makes each byte take 16 clock cycles. CS_GAP_SCLK = 2 then sets a four-cycle minimum chip-select gap that a bench monitor can measure exactly. The bench's flash model wraps inside a die, so a missed reissue shows up as wrong data.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_ID    = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_RX,
    ST_HOLD,
    ST_STEP,
    ST_GAP
  } st_e;

  localparam logic [7:0] CMD_READ      = 8'h03;
  localparam logic [7:0] CMD_ID        = 8'h9F;
  localparam logic [7:0] CMD_DIE_ERASE = 8'hC4;
endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q;
  logic             busy_q, sclk_q, done_q;
  logic             tick;

  assign tick = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        tx_q   <= tx_i;
        bit_q  <= '0;
        div_q  <= '0;
        sclk_q <= 1'b0;
      end else if (busy_q) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];

  // R2: MOSI settles on the falling edge only
  p_mosi_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
  // R2: no byte restarts mid-shift
  p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/flash_die_tracker.sv
module flash_die_tracker #(
  parameter int ADDR_W   = 27,
  parameter int DIE_BITS = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              die_base_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o     = addr_q;
  assign die_base_o = (addr_q[DIE_BITS-1:0] == '0);

  // R4: address advances by one per consumed byte
  p_inc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int NUM_DIES    = 4,
  parameter int DIE_BITS    = 25,
  parameter int LEN_W       = 16,
  parameter int CLK_DIV     = 2,
  parameter int CS_GAP_SCLK = 2,
  localparam int ADDR_W     = DIE_BITS + $clog2(NUM_DIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              done_o,
  output logic              spi_cs_no,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int DIE_W   = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1;
  localparam int GAP_CYC = 2 * CLK_DIV * CS_GAP_SCLK;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  st_e               st_q;
  op_e               op_q, req_op;
  logic [LEN_W-1:0]  rem_q;
  logic [2:0]        idx_q, hdr_last;
  logic              launched_q, last_q, done_q;
  logic [DIE_W-1:0]  die_q, die_nxt;
  logic [GAP_W-1:0]  gap_q;
  logic [7:0]        data_q, tx_byte, opcode, sh_rx;
  logic              sh_start, sh_busy, sh_done;
  logic              accept, trk_load, trk_inc, die_base;
  logic [ADDR_W-1:0] trk_addr, trk_load_addr;
  logic [31:0]       addr32;

  assign req_op   = op_e'(req_op_i);
  assign accept   = req_valid_i && req_ready_o;
  assign die_nxt  = die_q + 1'b1;
  assign hdr_last = (op_q == OP_ID) ? 3'd0 : 3'd4;
  assign addr32   = 32'(trk_addr);
  assign sh_start = (st_q == ST_TX || st_q == ST_RX) && !launched_q && !sh_busy;

  always_comb begin
    unique case (op_q)
      OP_ID:    opcode = CMD_ID;
      OP_ERASE: opcode = CMD_DIE_ERASE;
      default:  opcode = CMD_READ;
    endcase
    if (st_q == ST_RX) tx_byte = 8'h00;
    else begin
      unique case (idx_q)
        3'd0:    tx_byte = opcode;
        3'd1:    tx_byte = addr32[31:24];
        3'd2:    tx_byte = addr32[23:16];
        3'd3:    tx_byte = addr32[15:8];
        default: tx_byte = addr32[7:0];
      endcase
    end
  end

  // tracker loads on request accept and on each erase die step
  always_comb begin
    trk_load      = 1'b0;
    trk_load_addr = '0;
    if (st_q == ST_IDLE && accept) begin
      trk_load      = 1'b1;
      trk_load_addr = (req_op == OP_ERASE) ? '0 : req_addr_i;
    end else if (st_q == ST_GAP && gap_q == GAP_W'(GAP_CYC - 1) && !last_q
                 && op_q == OP_ERASE) begin
      trk_load      = 1'b1;
      trk_load_addr = ADDR_W'(die_nxt) << DIE_BITS;
    end
  end
  assign trk_inc = (st_q == ST_HOLD) && rd_ready_i;

  flash_die_tracker #(.ADDR_W(ADDR_W), .DIE_BITS(DIE_BITS)) u_trk (
    .clk_i, .rst_ni,
    .load_i(trk_load), .load_addr_i(trk_load_addr), .inc_i(trk_inc),
    .addr_o(trk_addr), .die_base_o(die_base)
  );

  flash_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
    .clk_i, .rst_ni,
    .start_i(sh_start), .tx_i(tx_byte), .miso_i(spi_miso_i),
    .busy_o(sh_busy), .done_o(sh_done), .rx_o(sh_rx),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_READ;
      rem_q      <= '0;
      idx_q      <= '0;
      launched_q <= 1'b0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      die_q      <= '0;
      gap_q      <= '0;
      data_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (sh_start) launched_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          op_q  <= req_op;
          die_q <= '0;
          idx_q <= '0;
          if (req_op == OP_READ && req_len_i == '0) done_q <= 1'b1;
          else begin
            rem_q <= (req_op == OP_ID) ? LEN_W'(3) : req_len_i;
            st_q  <= ST_TX;
          end
        end
        ST_TX: if (sh_done) begin
          launched_q <= 1'b0;
          if (idx_q == hdr_last) begin
            idx_q <= '0;
            if (op_q == OP_ERASE) begin
              last_q <= (die_q == DIE_W'(NUM_DIES - 1));
              st_q   <= ST_GAP;
            end else st_q <= ST_RX;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_RX: if (sh_done) begin
          launched_q <= 1'b0;
          data_q     <= sh_rx;
          st_q       <= ST_HOLD;
        end
        ST_HOLD: if (rd_ready_i) begin
          rem_q <= rem_q - 1'b1;
          st_q  <= ST_STEP;
        end
        ST_STEP: begin
          if (rem_q == '0) begin
            last_q <= 1'b1;
            st_q   <= ST_GAP;
          end else if (op_q == OP_READ && die_base) begin
            last_q <= 1'b0;
            st_q   <= ST_GAP;
          end else st_q <= ST_RX;
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            gap_q <= '0;
            if (last_q) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              if (op_q == OP_ERASE) die_q <= die_nxt;
              st_q <= ST_TX;
            end
          end else gap_q <= gap_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rd_valid_o  = (st_q == ST_HOLD);
  assign rd_data_o   = data_q;
  assign done_o      = done_q;
  assign spi_cs_no   = (st_q == ST_IDLE) || (st_q == ST_GAP);

  // consecutive chip-select high cycles, saturating
  logic [GAP_W-1:0] cs_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cs_hi_q <= GAP_W'(GAP_CYC);
    else if (!spi_cs_no)                   cs_hi_q <= '0;
    else if (cs_hi_q != GAP_W'(GAP_CYC))   cs_hi_q <= cs_hi_q + 1'b1;
  end

  p_sclk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && $stable(spi_sclk_o));
  p_zero_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && req_op_i == 2'd0 && req_len_i == '0 |=> done_o && spi_cs_no);
  p_cs_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> cs_hi_q >= GAP_W'(GAP_CYC));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> !req_ready_o);
  p_erase_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_q == OP_ERASE |-> !rd_valid_o);
endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  localparam int NUM_DIES = 4;
  localparam int DIE_BITS = 6;
  localparam int LEN_W    = 16;
  localparam int CLK_DIV  = 1;
  localparam int GAP_SCLK = 2;
  localparam int ADDR_W   = 8;
  localparam int GAP_CYC  = 2 * CLK_DIV * GAP_SCLK;
  localparam int DIE_MASK = (1 << DIE_BITS) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rd_ready = 1;
  logic [1:0] req_op = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic req_ready, rd_valid, done, cs_n, sclk, mosi, miso;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  flash_seq #(.NUM_DIES(NUM_DIES), .DIE_BITS(DIE_BITS), .LEN_W(LEN_W),
              .CLK_DIV(CLK_DIV), .CS_GAP_SCLK(GAP_SCLK)) u_flash_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .done_o(done), .spi_cs_no(cs_n), .spi_sclk_o(sclk),
    .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  // flash model: mode 0, wraps inside a die
  logic [7:0] m_rx = 0, m_tx = 0;
  int m_bit = 0, m_byte = 0, m_addr = 0;
  int txn = 0;
  logic [7:0] log_op [64];
  int log_addr [64];
  int log_nb [64];
  assign miso = m_tx[3'(7 - m_bit)];

  always @(negedge cs_n) begin
    m_bit = 0; m_byte = 0; m_tx = 8'h00; m_addr = 0;
    if (txn < 64) begin log_op[txn] = 0; log_addr[txn] = -1; end
    txn++;
  end
  always @(posedge cs_n) if (txn > 0 && txn <= 64) log_nb[txn-1] = m_byte;

  always @(posedge sclk) if (!cs_n) begin
    m_rx = {m_rx[6:0], mosi};
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0;
      if (m_byte == 0) log_op[txn-1] = m_rx;
      else if (m_byte <= 4) m_addr = (m_addr << 8) | int'(m_rx);
      if (log_op[txn-1] == 8'h9F) begin
        case (m_byte)
          0: m_tx = 8'h3C;
          1: m_tx = 8'h5A;
          2: m_tx = 8'h17;
          default: m_tx = 8'hFF;
        endcase
      end else if (log_op[txn-1] == 8'h03 && m_byte >= 4) begin
        if (m_byte == 4) log_addr[txn-1] = m_addr;
        else m_addr = (m_addr & ~DIE_MASK) | ((m_addr + 1) & DIE_MASK);
        m_tx = mem(m_addr);
      end else if (m_byte == 4) log_addr[txn-1] = m_addr;
      m_byte++;
    end
  end

  // R10 / R11 monitors
  int hi_cnt = 1000, gap_bad = 0, busy_bad = 0;
  always @(posedge clk) begin
    if (rst_n && !cs_n && req_ready) busy_bad++;
    if (cs_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < GAP_CYC) gap_bad++;
      hi_cnt = 0;
    end
  end

  logic [7:0] got [512];
  int got_n;
  bit done_seen;

  task automatic issue(input logic [1:0] op, input int addr, input int len);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
    check(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic collect();
    got_n = 0; done_seen = 0;
    for (int c = 0; c < 20000; c++) begin
      if (rd_valid && rd_ready && got_n < 512) begin got[got_n] = rd_data; got_n++; end
      if (done) begin done_seen = 1; break; end
      @(negedge clk);
    end
    check(done_seen, "R11", "completion seen", done_seen, 1);
    @(negedge clk);
    check(done == 1'b0, "R11", "done single cycle", done, 0);
  endtask

  task automatic run_read(input int addr, input int len, input int exp_txn);
    int t0 = txn;
    issue(2'd0, addr, len);
    collect();
    check(got_n == len, "R4", "byte count", got_n, len);
    for (int i = 0; i < got_n; i++)
      check(got[i] == mem((addr + i) & 8'hFF), "R4", "read byte", got[i], mem((addr + i) & 8'hFF));
    check(txn - t0 == exp_txn, "R5", "transaction count", txn - t0, exp_txn);
    for (int k = 0; k < txn - t0; k++) begin
      int ea = (k == 0) ? addr : (((addr >> DIE_BITS) + k) << DIE_BITS) & 8'hFF;
      check(log_op[t0+k] == 8'h03, "R3", "read opcode (R2 bit order)", log_op[t0+k], 8'h03);
      check(log_addr[t0+k] == ea, "R5", "read address", log_addr[t0+k], ea);
    end
  endtask

  task automatic t_reset();
    check(cs_n == 1'b1, "R1", "cs after reset", cs_n, 1);
    check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(rd_valid == 1'b0, "R1", "valid after reset", rd_valid, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic t_id();
    int t0 = txn;
    issue(2'd1, 8'h11, 9);
    collect();
    check(got_n == 3, "R6", "id byte count", got_n, 3);
    check(got[0] == 8'h3C && got[1] == 8'h5A && got[2] == 8'h17, "R6", "id bytes",
          {got[0], got[1], got[2]}, 24'h3C5A17);
    check(txn - t0 == 1, "R6", "id transactions", txn - t0, 1);
    check(log_op[t0] == 8'h9F, "R6", "id opcode", log_op[t0], 8'h9F);
    check(log_nb[t0] == 4, "R6", "id bytes clocked", log_nb[t0], 4);
  endtask

  task automatic t_erase();
    int t0 = txn;
    issue(2'd2, 8'h99, 5);
    collect();
    check(got_n == 0, "R7", "erase output bytes", got_n, 0);
    check(txn - t0 == NUM_DIES, "R7", "erase transactions", txn - t0, NUM_DIES);
    for (int d = 0; d < NUM_DIES; d++) begin
      check(log_op[t0+d] == 8'hC4, "R7", "erase opcode", log_op[t0+d], 8'hC4);
      check(log_addr[t0+d] == d << DIE_BITS, "R7", "erase die base", log_addr[t0+d], d << DIE_BITS);
      check(log_nb[t0+d] == 5, "R7", "erase length", log_nb[t0+d], 5);
    end
  endtask

  task automatic t_zero();
    int t0 = txn;
    issue(2'd0, 8'h20, 0);
    check(done == 1'b1, "R8", "zero length done", done, 1);
    check(cs_n == 1'b1, "R8", "zero length cs", cs_n, 1);
    @(negedge clk);
    check(done == 1'b0, "R8", "zero length pulse", done, 0);
    repeat (5) @(negedge clk);
    check(txn == t0, "R8", "no bus activity", txn - t0, 0);
  endtask

  task automatic t_backpressure();
    int n = 0;
    bit bad = 0;
    logic [7:0] held;
    rd_ready = 0;
    issue(2'd0, 8'h80, 3);
    for (int c = 0; c < 200 && !rd_valid; c++) @(negedge clk);
    held = rd_data;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (!rd_valid || rd_data !== held || sclk) bad = 1;
    end
    check(!bad, "R9", "stall holds byte and clock", bad, 0);
    check(held == mem(8'h80), "R9", "held byte", held, mem(8'h80));
    rd_ready = 1;
    collect();
    n = got_n;
    check(n == 3, "R9", "bytes after stall", n, 3);
    check(got[2] == mem(8'h82), "R9", "last byte after stall", got[2], mem(8'h82));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_read(8'h05, 10, 1);
    run_read(8'h3C, 8, 2);    // R5 single crossing
    run_read(8'h3E, 70, 3);   // R5 two crossings
    run_read(8'hFE, 4, 2);    // R5 top of device back to 0
    t_id();
    t_erase();
    t_zero();
    t_backpressure();
    check(gap_bad == 0, "R10", "short cs gaps", gap_bad, 0);
    check(busy_bad == 0, "R11", "ready while selected", busy_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule